// File: doc/BRIEF.md
# Variable-to-Fixed Rate Audio Resampler

This block takes stereo sample pairs that arrive at any rate from 8 kHz to 48 kHz and delivers stereo pairs at a fixed 44.1 kHz. It runs entirely from a single system clock of 384 × 44.1 kHz (16.9344 MHz). One output pair leaves every 384 clocks, whatever the input does. Arriving pairs are queued in a small stereo FIFO. A period meter counts the clocks between accepted input pairs. A hold stage runs at an intermediate rate of M × 44.1 kHz and fetches a new pair from the FIFO each time the accumulated intermediate time passes one input period. In between, it repeats the current pair (zero-order hold, upsampling by a variable N ≈ period / (384/M)). A fixed decimator then keeps every M-th intermediate value.

The input side is a valid/ready stream. A pair is taken on a clock where `in_valid` and `in_ready` are both high. While `in_ready` is low, the source must hold `in_valid`, `in_left` and `in_right` steady. `in_ready` drops only when the FIFO is full. The output side has no back-pressure: it is a one-cycle `out_valid` strobe at the fixed rate, and the sink must take the pair on that cycle. Left and right always travel as one packed word, so the two channels cannot slip against each other. Two sticky status pins, `overflow` and `underflow`, report a source that had to wait on a full FIFO and a hold stage that found no new pair when one was due.

Top module: `fixed_rate_resampler`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid`, `out_left`, `out_right`, `overflow` and `underflow` are all 0.
- R2: `out_valid` is a one-cycle pulse, high after exactly every OUT_PERIOD (384) rising edges counted from the end of reset, independent of the input.
- R3: A pair is accepted when `in_valid` and `in_ready` are both high. `in_ready` is low exactly when FIFO_DEPTH (4) pairs are queued, so a burst with no reads is accepted exactly 4 times.
- R4: `overflow` becomes 1 on the edge after a cycle with `in_valid` high and `in_ready` low, and stays 1 until reset. It stays 0 when the source runs at a steady rate of 8 kHz to 48 kHz.
- R5: When a fetch is due and the FIFO is empty, `underflow` becomes 1 (sticky) and the held pair is repeated; after reset the held pair is zero. With no input, the first fetch falls due on rising edge 384, so `underflow` reads 1 from then on.
- R6: With one input pair every 384 clocks, each output pair in steady state is the input pair following the one in the previous output.
- R7: With a steady input period P clocks, each output advances the input index by floor(384/P) or ceil(384/P), and over K outputs by K·384/P within ±2.
- R8: Pairs leave in arrival order: for a rising input sequence, the output sequence never decreases.
- R9: Every output pair has the left and right values of the same input pair; `out_left` is the upper DATA_W bits of the internal packed pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 384 × output rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | FIFO has space; pair accepted when both high |
| in_left | input | DATA_W | Left input sample |
| in_right | input | DATA_W | Right input sample |
| out_valid | output | 1 | One-cycle strobe at the fixed output rate |
| out_left | output | DATA_W | Left output sample |
| out_right | output | DATA_W | Right output sample |
| overflow | output | 1 | Sticky: source stalled on a full FIFO |
| underflow | output | 1 | Sticky: fetch found the FIFO empty |

## Verification
A wrong timebase count shows at the ports as a misplaced `out_valid` on the very first strobe, at edge 384, or on the next one. A fault in the hold accumulator or the period meter shows within a few output strobes, because the output index then steps by the wrong amount for the known input period. A corrupted FIFO pointer or level shows on the next fetch as a repeated, skipped or reordered pair, or as a left/right mismatch. It also shows at once when `in_ready` falls after the wrong number of burst accepts.

// File: rtl/frs_pkg.sv
package frs_pkg;

  // action the hold stage takes on an intermediate tick
  typedef enum logic [1:0] {
    HOLD_IDLE   = 2'd0,
    HOLD_LOAD   = 2'd1,
    HOLD_STARVE = 2'd2
  } hold_act_e;

  // bits needed to count 0..depth
  function automatic int unsigned frs_lvl_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

  // at least one bit for a counter over n states
  function automatic int unsigned frs_cnt_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/frs_pair_fifo.sv
module frs_pair_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty,
  output logic [LVL_W-1:0] level
);
  localparam int unsigned PTR_W = frs_pkg::frs_cnt_bits(DEPTH);
  localparam bit          POW2  = (DEPTH == (1 << PTR_W));

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
  logic             do_wr, do_rd;

  assign full  = (level == LVL_W'(DEPTH));
  assign empty = (level == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  // pointer wrap: free-running for power-of-two depths, compare otherwise
  generate
    if (POW2) begin : g_wrap_free
      assign wr_ptr_nx = wr_ptr + 1'b1;
      assign rd_ptr_nx = rd_ptr + 1'b1;
    end else begin : g_wrap_cmp
      assign wr_ptr_nx = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_ptr_nx = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr_nx;
      if (do_rd) rd_ptr <= rd_ptr_nx;
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/frs_period_meter.sv
module frs_period_meter #(
  parameter int unsigned PW     = 12,
  parameter int unsigned MIN_P  = 48,
  parameter int unsigned INIT_P = 384
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  output logic [PW-1:0] period
);
  localparam logic [PW-1:0] P_MAX = {PW{1'b1}};
  localparam logic [PW-1:0] P_MIN = PW'(MIN_P);
  localparam logic [PW-1:0] P_INI = PW'(INIT_P);

  logic [PW-1:0] gap, gap_inc, gap_clamped;
  logic          seen;

  // clocks since the last accepted pair, saturating
  assign gap_inc     = (gap == P_MAX) ? gap : gap + 1'b1;
  assign gap_clamped = (gap_inc < P_MIN) ? P_MIN : gap_inc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap    <= '0;
      seen   <= 1'b0;
      period <= P_INI;
    end else if (strobe) begin
      gap  <= '0;
      seen <= 1'b1;
      if (seen) period <= gap_clamped;
    end else begin
      gap <= gap_inc;
    end
  end

endmodule

// File: rtl/frs_timebase.sv
module frs_timebase #(
  parameter int unsigned OUT_PERIOD = 384,
  parameter int unsigned UPS_M      = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic dec_due
);
  localparam int unsigned TICK_LEN = OUT_PERIOD / UPS_M;
  localparam int unsigned TW       = frs_pkg::frs_cnt_bits(TICK_LEN);
  localparam int unsigned PHW      = frs_pkg::frs_cnt_bits(UPS_M);

  logic [TW-1:0]  tick_cnt;
  logic [PHW-1:0] phase;

  assign tick    = (tick_cnt == TW'(TICK_LEN - 1));
  assign dec_due = tick && (phase == PHW'(UPS_M - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      phase    <= '0;
    end else begin
      tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
      if (tick) phase <= dec_due ? '0 : phase + 1'b1;
    end
  end

endmodule

// File: rtl/frs_hold_stage.sv
module frs_hold_stage #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned PW    = 12,
  parameter int unsigned STEP  = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             dec_due,
  input  logic [PW-1:0]    period,
  input  logic             fifo_empty,
  input  logic [WIDTH-1:0] fifo_data,
  output logic             pop,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic             underflow
);
  import frs_pkg::*;

  localparam int unsigned AW = PW + 1;

  logic [AW-1:0]    acc, acc_sum, acc_rem, per_ext, acc_nx;
  logic [WIDTH-1:0] hold;
  hold_act_e        act;

  assign per_ext = {1'b0, period};
  assign acc_sum = acc + AW'(STEP);
  assign acc_rem = acc_sum - per_ext;
  // a backlog left by a sudden period drop is discarded, not replayed
  assign acc_nx  = (act == HOLD_IDLE) ? acc_sum :
                   (acc_rem >= per_ext) ? '0 : acc_rem;

  always_comb begin
    act = HOLD_IDLE;
    if (tick && (acc_sum >= per_ext))
      act = fifo_empty ? HOLD_STARVE : HOLD_LOAD;
  end

  assign pop = (act == HOLD_LOAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      hold      <= '0;
      underflow <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (tick) acc <= acc_nx;
      if (act == HOLD_LOAD)   hold      <= fifo_data;
      if (act == HOLD_STARVE) underflow <= 1'b1;
      out_valid <= dec_due;
      if (dec_due) out_data <= hold;
    end
  end

endmodule

// File: rtl/fixed_rate_resampler.sv
module fixed_rate_resampler #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned OUT_PERIOD = 384,
  parameter int unsigned UPS_M      = 8,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned PERIOD_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right,
  output logic              overflow,
  output logic              underflow
);
  localparam int unsigned PAIR_W = 2 * DATA_W;
  localparam int unsigned STEP   = OUT_PERIOD / UPS_M;
  localparam int unsigned LVL_W  = frs_pkg::frs_lvl_bits(FIFO_DEPTH);

  logic              accept, fifo_full, fifo_empty, pop, tick, dec_due;
  logic [PAIR_W-1:0] in_pair, head_pair, out_pair;
  logic [LVL_W-1:0]  fifo_level;
  logic [PERIOD_W-1:0] period;

  // both channels travel as one word so they cannot drift apart
  assign in_pair  = {in_left, in_right};
  assign in_ready = !fifo_full;
  assign accept   = in_valid && in_ready;

  frs_pair_fifo #(
    .WIDTH (PAIR_W),
    .DEPTH (FIFO_DEPTH),
    .LVL_W (LVL_W)
  ) i_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept),
    .wr_data (in_pair),
    .rd_en   (pop),
    .rd_data (head_pair),
    .full    (fifo_full),
    .empty   (fifo_empty),
    .level   (fifo_level)
  );

  frs_period_meter #(
    .PW     (PERIOD_W),
    .MIN_P  (STEP),
    .INIT_P (OUT_PERIOD)
  ) i_meter (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (accept),
    .period (period)
  );

  frs_timebase #(
    .OUT_PERIOD (OUT_PERIOD),
    .UPS_M      (UPS_M)
  ) i_timebase (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .dec_due (dec_due)
  );

  frs_hold_stage #(
    .WIDTH (PAIR_W),
    .PW    (PERIOD_W),
    .STEP  (STEP)
  ) i_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .dec_due    (dec_due),
    .period     (period),
    .fifo_empty (fifo_empty),
    .fifo_data  (head_pair),
    .pop        (pop),
    .out_valid  (out_valid),
    .out_data   (out_pair),
    .underflow  (underflow)
  );

  assign out_left  = out_pair[PAIR_W-1 -: DATA_W];
  assign out_right = out_pair[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)                   overflow <= 1'b0;
    else if (in_valid && !in_ready) overflow <= 1'b1;
  end

endmodule

// File: rtl/frs_checker.sv
module frs_checker #(
  parameter int unsigned OUT_PERIOD = 384,
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned LVL_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             overflow,
  input logic             underflow,
  input logic [LVL_W-1:0] fifo_level
);
  localparam int unsigned GW = $clog2(OUT_PERIOD + 1) + 1;

  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n)         gap <= '0;
    else if (out_valid) gap <= GW'(1);
    else                gap <= gap + 1'b1;
  end

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R2
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (gap == GW'(OUT_PERIOD)));

  // R2
  strobe_not_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap <= GW'(OUT_PERIOD));

  // R3
  ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (fifo_level == LVL_W'(DEPTH)));

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  // R4
  overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> overflow);

  // R4
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R5
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

endmodule

bind fixed_rate_resampler frs_checker #(
  .OUT_PERIOD (OUT_PERIOD),
  .DEPTH      (FIFO_DEPTH),
  .LVL_W      (LVL_W)
) i_frs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .overflow   (overflow),
  .underflow  (underflow),
  .fifo_level (fifo_level)
);

// File: tb/test_fixed_rate_resampler.sv
module test_fixed_rate_resampler;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 16;
  localparam int OUTP       = 384;
  localparam int LOG_N      = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_left = '0, in_right = '0;
  logic          out_valid;
  logic [DW-1:0] out_left, out_right;
  logic          overflow, underflow;

  int checks = 0, failures = 0;
  int edge_k = 0, n_out = 0, gap_err = 0;
  int drv_period = 0, drv_cnt = 0, seq = 1, accepts = 0;
  bit pend_rdy = 1'b0;
  int log_l [LOG_N];
  int log_r [LOG_N];

  fixed_rate_resampler i_fixed_rate_resampler (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready),
    .in_left (in_left), .in_right (in_right),
    .out_valid (out_valid), .out_left (out_left), .out_right (out_right),
    .overflow (overflow), .underflow (underflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int swp(input int v);
    return ((v & 8'hFF) << 8) | ((v >> 8) & 8'hFF);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) edge_k <= 0;
    else        edge_k <= edge_k + 1;
  end

  // monitor: strobe placement and output log
  always @(negedge clk) begin
    if (!rst_n) n_out = 0;
    else begin
      if (edge_k > 0 && (out_valid !== ((edge_k % OUTP) == 0))) gap_err++;
      if (out_valid && n_out < LOG_N) begin
        log_l[n_out] = int'(out_left);
        log_r[n_out] = int'(out_right);
        n_out++;
      end
    end
  end

  // source: one pair every drv_period clocks, holding while not ready
  always @(negedge clk) begin
    if (!rst_n) begin
      in_valid = 1'b0; drv_cnt = 0; seq = 1; accepts = 0; pend_rdy = 1'b0;
    end else begin
      if (in_valid && pend_rdy) begin accepts++; in_valid = 1'b0; end
      if (drv_period == 0) in_valid = 1'b0;
      else if (!in_valid) begin
        if (drv_cnt >= drv_period - 1) begin
          in_valid = 1'b1;
          in_left  = DW'(seq);
          in_right = DW'(swp(seq));
          seq++;
          drv_cnt = 0;
        end else drv_cnt++;
      end
      pend_rdy = in_ready;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    drv_period = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_edge(input int k);
    while (edge_k < k) @(negedge clk);
    #1;
  endtask

  task automatic wait_outs(input int n);
    while (n_out < n) @(negedge clk);
    #1;
  endtask

  task automatic sweep(input string req, input int p, input int s, input int e,
                       input int lo, input int hi, input int slo, input int shi);
    int bad_step = 0, bad_dec = 0, bad_pair = 0, sum;
    do_reset();
    drv_period = p;
    wait_outs(e + 1);
    for (int i = s + 1; i <= e; i++) begin
      int d = log_l[i] - log_l[i-1];
      if (d < lo || d > hi) bad_step++;
      if (d < 0) bad_dec++;
    end
    for (int i = 0; i <= e; i++)
      if (log_r[i] != swp(log_l[i])) bad_pair++;
    sum = log_l[e] - log_l[s];
    check(bad_step == 0, req, $sformatf("step range P=%0d", p), bad_step, 0);
    check(sum >= slo && sum <= shi, req, $sformatf("index advance P=%0d", p), sum, (slo + shi) / 2);
    check(bad_dec == 0, "R8", $sformatf("order P=%0d", p), bad_dec, 0);
    check(bad_pair == 0, "R9", $sformatf("channel pairing P=%0d", p), bad_pair, 0);
    check(overflow == 1'b0, "R4", $sformatf("no overflow P=%0d", p), int'(overflow), 0);
    check(gap_err == 0, "R2", $sformatf("strobe grid P=%0d", p), gap_err, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state, R5 underflow with idle input
    do_reset();
    #1;
    check(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
    check(out_left == '0 && out_right == '0, "R1", "out data", int'(out_left), 0);
    check(overflow == 1'b0, "R1", "overflow", int'(overflow), 0);
    check(underflow == 1'b0, "R1", "underflow", int'(underflow), 0);
    wait_edge(383);
    check(underflow == 1'b0, "R5", "underflow before first fetch", int'(underflow), 0);
    wait_edge(385);
    check(underflow == 1'b1, "R5", "underflow after first fetch", int'(underflow), 1);
    check(n_out == 1 && log_l[0] == 0, "R5", "held zero pair", log_l[0], 0);
    wait_edge(OUTP * 4 + 2);
    check(gap_err == 0 && n_out == 4, "R2", "idle strobe count", n_out, 4);

    // R6 input at the output rate: exact single steps
    sweep("R6", 384, 10, 39, 1, 1, 29, 29);
    // R7 half rate, 48 kHz-like and 8 kHz-like periods
    sweep("R7", 768, 10, 29, 0, 1, 9, 11);
    sweep("R7", 348, 10, 39, 1, 2, 31, 35);
    sweep("R7", 2117, 15, 44, 0, 1, 3, 8);

    // R3/R4 burst into full FIFO, then R5 repeat of last pair
    do_reset();
    drv_period = 1;
    wait_edge(12);
    check(accepts == 4, "R3", "burst accepts", accepts, 4);
    check(in_ready == 1'b0, "R3", "in_ready when full", int'(in_ready), 0);
    check(overflow == 1'b1, "R4", "overflow set", int'(overflow), 1);
    drv_period = 0;
    wait_edge(OUTP * 2 + 2);
    check(overflow == 1'b1, "R4", "overflow sticky", int'(overflow), 1);
    check(underflow == 1'b1, "R5", "underflow after drain", int'(underflow), 1);
    check(n_out == 2 && log_l[0] == 4, "R8", "last burst pair out", log_l[0], 4);
    check(log_r[0] == swp(4), "R9", "last burst right", log_r[0], swp(4));
    check(log_l[1] == 4, "R5", "repeat of held pair", log_l[1], 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule